// File: doc/BRIEF.md
# Multi-Cycle Accumulate-and-Average Processor Core

This block is a small sequential processor. Each instruction runs as a fixed series of phases. It first reads an instruction word from a shared memory into an instruction register. It then interprets that word, and then carries it out. A single synchronous memory of 256 sixteen-bit words holds both program and data. Four general-purpose registers feed a small arithmetic unit that can add two registers or divide a register by an immediate constant. The memory is read twice for a load: once for the instruction and once for the data word. A store writes it during the execute step.

A program is placed in memory through a loading port that is honoured only while reset is held. When reset is released, execution starts at address 0 with every register cleared. An all-ones instruction word halts the sequencer and raises `done`. A debug view of the phase, program counter and all four registers lets a bench follow the core cycle by cycle.

Instruction word layout (bit 15 is the MSB): opcode in [15:14] (0 = load, 1 = store, 2 = add, 3 = divide). Destination register in [13:12]. Source A in [11:10]. Source B in [9:8]. Memory address or immediate in [7:0]. A register index of 0..3 selects R1..R4.

Top module: `toy_cpu`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, the phase is 0 (fetch), the PC is 0, all four registers are 0 and `done` is 0.
- R2: Phases are encoded fetch=0, fetch-wait=1, decode=2, execute=3, load-wait=4, halted=5. They run fetch, fetch-wait, decode, execute. Fetch increments the PC by one, and fetch-wait captures the memory word at the old PC into the instruction register.
- R3: The decode phase changes no register, no memory word and not the PC.
- R4: A load (opcode 0) reads the word at the address field and writes it to the destination register at the end of the load-wait phase.
- R5: A store (opcode 1) writes the register named by the destination field [13:12] to memory at the address field during execute. The written value can then be read by a later load.
- R6: An add (opcode 2) writes source A + source B, modulo 2^16, to the destination register.
- R7: A divide (opcode 3) writes source A divided by the 8-bit immediate to the destination register, as an unsigned division truncated toward zero. A zero immediate writes 0xFFFF.
- R8: The word 0xFFFF, seen in decode, moves the phase to halted and sets `done`. After that, the phase, PC, `done` and registers stay frozen.
- R9: The register fields select R1..R4 by the indices 0..3, in the bit positions given above.
- R10: The loading port writes memory only while `rst` is high. A `ld_en` pulse while running leaves memory unchanged.
- R11: A program that loads 84 and 92, adds them, divides by 2 and stores the quotient leaves 88 at the result address.
- R12: A load takes 5 cycles from fetch to the next fetch, and every other instruction takes 4. The halt word raises `done` 3 cycles after its fetch begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also enables program loading |
| ld_en | input | 1 | Write strobe of the loading port (honoured only in reset) |
| ld_addr | input | 8 | Loading port word address |
| ld_data | input | 16 | Loading port write data |
| done | output | 1 | High once the halt word has been decoded |
| dbg_phase | output | 3 | Current phase code |
| dbg_pc | output | 8 | Program counter |
| dbg_r1 | output | 16 | Register R1 |
| dbg_r2 | output | 16 | Register R2 |
| dbg_r3 | output | 16 | Register R3 |
| dbg_r4 | output | 16 | Register R4 |

## Verification
A wrong phase transition or a wrong PC step shows on `dbg_phase` or `dbg_pc` on the very next clock. A wrong register write shows on the debug register outputs on the edge that ends the execute or load-wait phase. A wrong memory write cannot be seen directly. It shows only when a later load brings the word back into a register, so the programs re-read every stored location. The bench therefore runs a cycle-accurate behavioural model beside the core and compares every debug output on every cycle.

// File: rtl/toycpu_pkg.sv
package toycpu_pkg;
  typedef enum logic [2:0] {
    PH_FETCH  = 3'd0,
    PH_FWAIT  = 3'd1,
    PH_DECODE = 3'd2,
    PH_EXEC   = 3'd3,
    PH_XWAIT  = 3'd4,
    PH_HALT   = 3'd5
  } phase_t;

  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_STORE = 2'd1,
    OP_ADD   = 2'd2,
    OP_DIV   = 2'd3
  } opcode_t;

  localparam int NUM_REGS = 4;
  localparam int REG_IDX_W = $clog2(NUM_REGS);
endpackage

// File: rtl/tc_ram.sv
// Single-port synchronous RAM, read-before-write, one-cycle read latency.
module tc_ram #(
  parameter int DW = 16,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/tc_regfile.sv
// Register bank with one write port; all entries visible in parallel.
module tc_regfile #(
  parameter int DW    = 16,
  parameter int NREG  = 4,
  parameter int IDX_W = $clog2(NREG)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      we,
  input  logic [IDX_W-1:0]          waddr,
  input  logic [DW-1:0]             wdata,
  output logic [NREG-1:0][DW-1:0]   q
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        q[g] <= '0;
      end else if (we && (waddr == IDX_W'(g))) begin
        q[g] <= wdata;
      end
    end
  end
endmodule

// File: rtl/tc_alu.sv
// Adder and immediate divider. A zero divisor saturates to all ones.
module tc_alu #(
  parameter int DW   = 16,
  parameter int IMMW = 8
) (
  input  logic            is_div,
  input  logic [DW-1:0]   src_a,
  input  logic [DW-1:0]   src_b,
  input  logic [IMMW-1:0] imm,
  output logic [DW-1:0]   y
);
  localparam int PADW = DW - IMMW;

  logic [DW-1:0] divisor;
  logic [DW-1:0] quotient;

  always_comb begin
    divisor  = {{PADW{1'b0}}, imm};
    quotient = (imm == '0) ? '1 : (src_a / divisor);
    y        = is_div ? quotient : (src_a + src_b);
  end
endmodule

// File: rtl/tc_sequencer.sv
// Phase controller: owns PC, instruction register and halt flag.
module tc_sequencer
  import toycpu_pkg::*;
#(
  parameter int          DW       = 16,
  parameter int          AW       = 8,
  parameter logic [AW-1:0] START_PC = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] mem_rdata,
  output phase_t        phase,
  output logic [AW-1:0] pc,
  output logic [DW-1:0] ir,
  output logic          done
);
  localparam logic [DW-1:0] HALT_WORD = '1;

  opcode_t op;
  assign op = opcode_t'(ir[DW-1 -: 2]);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_FETCH;
      pc    <= START_PC;
      ir    <= '0;
      done  <= 1'b0;
    end else begin
      unique case (phase)
        PH_FETCH: begin
          pc    <= pc + AW'(1);
          phase <= PH_FWAIT;
        end
        PH_FWAIT: begin
          ir    <= mem_rdata;
          phase <= PH_DECODE;
        end
        PH_DECODE: begin
          if (ir == HALT_WORD) begin
            phase <= PH_HALT;
            done  <= 1'b1;
          end else begin
            phase <= PH_EXEC;
          end
        end
        PH_EXEC:  phase <= (op == OP_LOAD) ? PH_XWAIT : PH_FETCH;
        PH_XWAIT: phase <= PH_FETCH;
        PH_HALT:  phase <= PH_HALT;
        default:  phase <= PH_FETCH;
      endcase
    end
  end

  // R2: fetch steps the PC by one
  p_fetch_pc_inc_r2: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_FETCH) |=> (pc == $past(pc) + AW'(1)));

  // R2: fetch-wait is always followed by decode
  p_fwait_to_decode_r2: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_FWAIT) |=> (phase == PH_DECODE));

  // R12: non-load execute returns straight to fetch
  p_exec_short_r12: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_EXEC && op != OP_LOAD) |=> (phase == PH_FETCH));

  // R8: halted state is sticky and freezes the PC
  p_halt_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> (done && phase == PH_HALT && $stable(pc)));
endmodule

// File: rtl/toy_cpu.sv
module toy_cpu
  import toycpu_pkg::*;
#(
  parameter int            DW       = 16,
  parameter int            AW       = 8,
  parameter logic [AW-1:0] START_PC = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_en,
  input  logic [AW-1:0] ld_addr,
  input  logic [DW-1:0] ld_data,
  output logic          done,
  output logic [2:0]    dbg_phase,
  output logic [AW-1:0] dbg_pc,
  output logic [DW-1:0] dbg_r1,
  output logic [DW-1:0] dbg_r2,
  output logic [DW-1:0] dbg_r3,
  output logic [DW-1:0] dbg_r4
);
  localparam int IW = REG_IDX_W;

  phase_t                       phase;
  logic [AW-1:0]                pc;
  logic [DW-1:0]                ir;
  logic [DW-1:0]                mem_rdata;
  logic [DW-1:0]                mem_wdata;
  logic [AW-1:0]                mem_addr;
  logic                         mem_we;
  logic [NUM_REGS-1:0][DW-1:0]  regs;
  logic                         rf_we;
  logic [DW-1:0]                rf_wdata;
  logic [DW-1:0]                alu_y;

  opcode_t       op;
  logic [IW-1:0] f_rd, f_ra, f_rb;
  logic [AW-1:0] f_addr;

  assign op     = opcode_t'(ir[DW-1 -: 2]);
  assign f_rd   = ir[DW-3 -: IW];
  assign f_ra   = ir[DW-5 -: IW];
  assign f_rb   = ir[DW-7 -: IW];
  assign f_addr = ir[AW-1:0];

  tc_sequencer #(.DW(DW), .AW(AW), .START_PC(START_PC)) u_seq (
    .clk(clk), .rst(rst), .mem_rdata(mem_rdata),
    .phase(phase), .pc(pc), .ir(ir), .done(done)
  );

  // Memory port: loader owns it during reset, the core afterwards.
  always_comb begin
    if (rst) begin
      mem_addr  = ld_addr;
      mem_we    = ld_en;
      mem_wdata = ld_data;
    end else begin
      mem_addr  = (phase == PH_FETCH) ? pc : f_addr;
      mem_we    = (phase == PH_EXEC) && (op == OP_STORE);
      mem_wdata = regs[f_rd];
    end
  end

  tc_ram #(.DW(DW), .AW(AW)) u_ram (
    .clk(clk), .we(mem_we), .addr(mem_addr), .wdata(mem_wdata), .rdata(mem_rdata)
  );

  tc_alu #(.DW(DW), .IMMW(AW)) u_alu (
    .is_div(op == OP_DIV), .src_a(regs[f_ra]), .src_b(regs[f_rb]),
    .imm(f_addr), .y(alu_y)
  );

  always_comb begin
    rf_we    = (phase == PH_XWAIT) ||
               ((phase == PH_EXEC) && (op == OP_ADD || op == OP_DIV));
    rf_wdata = (phase == PH_XWAIT) ? mem_rdata : alu_y;
  end

  tc_regfile #(.DW(DW), .NREG(NUM_REGS), .IDX_W(IW)) u_rf (
    .clk(clk), .rst(rst), .we(rf_we), .waddr(f_rd), .wdata(rf_wdata), .q(regs)
  );

  assign dbg_phase = phase;
  assign dbg_pc    = pc;
  assign dbg_r1    = regs[0];
  assign dbg_r2    = regs[1];
  assign dbg_r3    = regs[2];
  assign dbg_r4    = regs[3];

  // R3: decode writes neither the register bank nor memory
  p_decode_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_DECODE) |-> (!rf_we && !mem_we));

  // R4: the load-wait capture lands in the destination register
  p_load_capture_r4: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_XWAIT) |=> (regs[$past(f_rd)] == $past(mem_rdata)));

  // R7: a non-zero divisor never yields more than the dividend
  p_div_bound_r7: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_EXEC && op == OP_DIV && f_addr != '0) |-> (alu_y <= regs[f_ra]));
endmodule

// File: tb/test_toy_cpu.sv
`timescale 1ns/1ps
module test_toy_cpu;
  logic        clk = 1'b0;
  logic        rst;
  logic        ld_en;
  logic [7:0]  ld_addr;
  logic [15:0] ld_data;
  logic        done;
  logic [2:0]  dbg_phase;
  logic [7:0]  dbg_pc;
  logic [15:0] dbg_r1, dbg_r2, dbg_r3, dbg_r4;

  always #4 clk = ~clk;

  toy_cpu i_toy_cpu (
    .clk(clk), .rst(rst), .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
    .done(done), .dbg_phase(dbg_phase), .dbg_pc(dbg_pc),
    .dbg_r1(dbg_r1), .dbg_r2(dbg_r2), .dbg_r3(dbg_r3), .dbg_r4(dbg_r4)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;

  // Behavioural reference state
  logic [15:0] m_mem [256];
  logic [15:0] m_reg [4];
  int          m_pc, m_ph;
  logic [15:0] m_ir, m_pend;
  bit          m_done;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  function automatic logic [15:0] enc(int op, int rd, int ra, int rb, int imm);
    return 16'((op << 14) | (rd << 12) | (ra << 10) | (rb << 8) | (imm & 255));
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic put(int addr, logic [15:0] data);
    ld_en = 1'b1; ld_addr = 8'(addr); ld_data = data;
    @(negedge clk);
    ld_en = 1'b0;
    m_mem[addr] = data;
  endtask

  task automatic start_reset();
    rst = 1'b1; ld_en = 1'b0; ld_addr = '0; ld_data = '0;
    repeat (2) @(negedge clk);
  endtask

  task automatic release_reset();
    rst = 1'b0;
    m_pc = 0; m_ph = 0; m_ir = '0; m_pend = '0; m_done = 1'b0;
    for (int i = 0; i < 4; i++) m_reg[i] = '0;
    #1;
    check("R1 phase", 32'(dbg_phase), 0);
    check("R1 pc", 32'(dbg_pc), 0);
    check("R1 regs", {dbg_r1 | dbg_r2, dbg_r3 | dbg_r4}, 0);
    check("R1 done", 32'(done), 0);
  endtask

  task automatic model_step();
    int op, rd, ra, rb, imm;
    op = int'(m_ir[15:14]); rd = int'(m_ir[13:12]); ra = int'(m_ir[11:10]);
    rb = int'(m_ir[9:8]); imm = int'(m_ir[7:0]);
    case (m_ph)
      0: begin m_pend = m_mem[m_pc]; m_pc = (m_pc + 1) % 256; m_ph = 1; end
      1: begin m_ir = m_pend; m_ph = 2; end
      2: begin
        if (m_ir == 16'hFFFF) begin m_ph = 5; m_done = 1'b1; end
        else m_ph = 3;
      end
      3: begin
        case (op)
          0: begin m_pend = m_mem[imm]; m_ph = 4; end
          1: begin m_mem[imm] = m_reg[rd]; m_ph = 0; end
          2: begin m_reg[rd] = 16'(m_reg[ra] + m_reg[rb]); m_ph = 0; end
          default: begin
            m_reg[rd] = (imm == 0) ? 16'hFFFF : 16'(int'(m_reg[ra]) / imm);
            m_ph = 0;
          end
        endcase
      end
      4: begin m_reg[rd] = m_pend; m_ph = 0; end
      default: m_ph = 5;
    endcase
  endtask

  // Runs until 8 cycles past done; returns the cycle in which done appeared.
  task automatic run(int maxc, int poke_at, int poke_addr, logic [15:0] poke_data,
                     output int done_cyc);
    done_cyc = 0;
    for (int c = 1; c <= maxc; c++) begin
      if (c == poke_at) begin
        ld_en = 1'b1; ld_addr = 8'(poke_addr); ld_data = poke_data;
      end
      @(posedge clk);
      model_step();
      @(negedge clk);
      ld_en = 1'b0;
      check("R2 phase", 32'(dbg_phase), 32'(m_ph));
      check("R2/R3 pc", 32'(dbg_pc), 32'(m_pc));
      check("R4/R5/R6/R7 r1", 32'(dbg_r1), 32'(m_reg[0]));
      check("R4/R5/R6/R7 r2", 32'(dbg_r2), 32'(m_reg[1]));
      check("R4/R5/R6/R7 r3", 32'(dbg_r3), 32'(m_reg[2]));
      check("R4/R5/R6/R7 r4", 32'(dbg_r4), 32'(m_reg[3]));
      check("R8 done", 32'(done), 32'(m_done));
      if (done && done_cyc == 0) done_cyc = c;
      if (done_cyc != 0 && c >= done_cyc + 8) break;
    end
  endtask

  initial begin
    int dc;
    int pc_at_halt;
    for (int i = 0; i < 256; i++) m_mem[i] = '0;

    // Program 1: average of two scores, then re-read the stored result
    start_reset();
    put(0, enc(0, 0, 0, 0, 8'h80));   // LOAD R1
    put(1, enc(0, 1, 0, 0, 8'h81));   // LOAD R2
    put(2, enc(2, 2, 0, 1, 0));       // ADD R3,R1,R2
    put(3, enc(3, 3, 2, 0, 2));       // DIV R4,R3,2
    put(4, enc(1, 3, 0, 0, 8'h82));   // STORE R4
    put(5, enc(0, 0, 0, 0, 8'h82));   // LOAD R1 from result
    put(6, 16'hFFFF);
    put(8'h80, 16'd84);
    put(8'h81, 16'd92);
    put(8'h82, 16'd0);
    release_reset();
    run(200, 0, 0, '0, dc);
    check("R11 average in R4", 32'(dbg_r4), 88);
    check("R5 stored word reloaded", 32'(dbg_r1), 88);
    check("R6 sum", 32'(dbg_r3), 176);
    check("R9 R2 field", 32'(dbg_r2), 92);
    check("R12 cycles to done", 32'(dc), 30);
    check("R8 halted pc", 32'(dbg_pc), 7);

    // Program 2: wrap-around add, divide by zero, truncation, load-port ignore
    start_reset();
    put(0, enc(0, 0, 0, 0, 8'h90));   // LOAD R1 = FFF0
    put(1, enc(0, 1, 0, 0, 8'h91));   // LOAD R2 = 0020
    put(2, enc(2, 2, 0, 1, 0));       // ADD R3 = 0010
    put(3, enc(3, 3, 0, 0, 0));       // DIV R4 = R1/0
    put(4, enc(3, 1, 0, 0, 11));      // DIV R2 = R1/11
    put(5, enc(0, 0, 0, 0, 8'h92));   // LOAD R1 = 0005
    put(6, 16'hFFFF);
    put(8'h90, 16'hFFF0);
    put(8'h91, 16'h0020);
    put(8'h92, 16'h0005);
    release_reset();
    run(200, 3, 8'h92, 16'h1234, dc);
    check("R6 add wraps", 32'(dbg_r3), 32'h0010);
    check("R7 divide by zero", 32'(dbg_r4), 32'hFFFF);
    check("R7 truncating divide", 32'(dbg_r2), 5956);
    check("R10 load port ignored when running", 32'(dbg_r1), 5);
    check("R12 cycles to done", 32'(dc), 30);
    pc_at_halt = int'(dbg_pc);
    repeat (5) @(negedge clk);
    check("R8 pc frozen", 32'(dbg_pc), 32'(pc_at_halt));
    check("R8 phase stays halted", 32'(dbg_phase), 5);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule